// File: doc/BRIEF.md
# Loop and Case Branch Resolver

This unit decides the outcome of the counted-loop and multiway-branch operations of an integer execution pipe. Each cycle in which `valid_i` is high it takes an opcode, an operand size, an index, a limit, an addend, a case base and the incoming condition flags. One clock later it presents the updated index, the condition flags, a branch-taken bit and, for case selection, the number of the displacement-table entry to use.

Loop operations step the index by an addend, by +1 or by -1, and compare the wrapped result against a limit or against zero as signed two's-complement values at the operand width. Case selection subtracts the base from the index and bounds the difference with a single unsigned compare, so selectors below the base are also rejected. When no case entry is chosen, the unit reports the entry just past the table (limit + 1), so that fetch can skip the table. Fetching displacements and forming the target address are left to the surrounding logic.

Top module: `lbr_resolver`

## Requirements
- R1: Results register one cycle after a cycle with `valid_i` high, with `valid_o` high in that cycle only. While `valid_i` is low, all result outputs hold their values. Reset clears every output to zero.
- R2: The step-and-compare op (`op_i`=0) produces new index = index + addend at the operand width. The branch is taken when the addend is zero or positive and new index <= limit, or when the addend is negative and new index >= limit. All comparisons are signed.
- R3: The flags are packed as `flags_o[3:0]` = {N, Z, V, C}. For ops 0..4, N is the sign of the new index, Z is set when the new index is zero and V is signed overflow of the update, while C is copied from `flags_i[0]`. For ops 5..7, `flags_o` equals `flags_i`.
- R4: The increment forms (op 1 = strictly-less, op 2 = less-or-equal) add 1 to a 32-bit index and compare it, signed, against a 32-bit limit.
- R5: The decrement forms (op 3 = greater-than-zero, op 4 = greater-or-equal-zero) subtract 1 from a 32-bit index and compare it, signed, against zero.
- R6: Low-bit test: op 5 branches when `index_i[0]` is 0, and op 6 branches when it is 1. The index leaves unchanged.
- R7: Case (op 7) forms selector = index - base at the operand width. The branch is taken when the selector is unsigned <= the limit, and `sel_o` then carries the selector zero-extended. The index leaves unchanged.
- R8: When a case branch is not taken, `sel_o` = limit (zero-extended at the operand width) + 1, held in W+1 bits. For every non-case op, `sel_o` is 0.
- R9: `size_i` selects the operand width for ops 0 and 7: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Ops 1..6 always use 32 bits. For 8 and 16 bits, the upper bits of `index_o` are copied from `index_i`.
- R10: When the index update overflows, V is set and the branch decision uses the wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Opcode: 0 step-compare, 1 inc-lt, 2 inc-le, 3 dec-gt, 4 dec-ge, 5 low-bit-clear, 6 low-bit-set, 7 case |
| size_i | input | 2 | Operand width for ops 0 and 7 |
| index_i | input | W | Index / source operand |
| limit_i | input | W | Loop limit or case table bound |
| addend_i | input | W | Step for op 0 |
| base_i | input | W | Case base |
| flags_i | input | 4 | Incoming {N,Z,V,C} |
| valid_o | output | 1 | Result valid |
| index_o | output | W | Updated index |
| taken_o | output | 1 | Branch taken |
| sel_o | output | W+1 | Case table entry or fall-through entry |
| flags_o | output | 4 | Outgoing {N,Z,V,C} |

## Verification
The bench targets limit equality in both step directions. A design that tests the wrong sign of the addend, or uses a strict compare, would take or skip the branch exactly at the limit. Byte and word updates that wrap from +max to -min must set V, keep the upper index bits and still branch on the wrapped value; a design that uses the 32-bit value or clears the upper bits would mismatch there. Case selectors below the base must fall through to limit+1, which a signed or two-sided compare would mishandle. Decrement to exactly zero and to -1 separates the greater-than form from the greater-or-equal form.

// File: rtl/lbr_pkg.sv
`timescale 1ns/1ps
package lbr_pkg;
  typedef enum logic [2:0] {
    OP_ACB     = 3'd0,
    OP_AOB_LT  = 3'd1,
    OP_AOB_LE  = 3'd2,
    OP_SOB_GT  = 3'd3,
    OP_SOB_GE  = 3'd4,
    OP_BLB_CLR = 3'd5,
    OP_BLB_SET = 3'd6,
    OP_CASE    = 3'd7
  } op_e;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_L = 2'd2;

  localparam int FLAG_W = 4;
endpackage

// File: rtl/lbr_ext.sv
`timescale 1ns/1ps
module lbr_ext
  import lbr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [1:0]   sz_i,
  input  logic         sgn_i,
  output logic [W:0]   y_o
);
  always_comb begin
    unique case (sz_i)
      SZ_B:    y_o = {{(W-7){sgn_i & x_i[7]}}, x_i[7:0]};
      SZ_H:    y_o = {{(W-15){sgn_i & x_i[15]}}, x_i[15:0]};
      default: y_o = {sgn_i & x_i[W-1], x_i};
    endcase
  end
endmodule

// File: rtl/lbr_step.sv
`timescale 1ns/1ps
module lbr_step
  import lbr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] idx_i,
  input  logic [W-1:0] add_i,
  input  logic [1:0]   sz_i,
  output logic [W-1:0] res_o,
  output logic [W:0]   sres_o,
  output logic         ovf_o
);
  localparam int EW = W + 1;

  logic [EW-1:0] ia, aa, sum;
  logic [W-1:0]  low;

  lbr_ext #(.W(W)) u_ext_idx (.x_i(idx_i), .sz_i(sz_i), .sgn_i(1'b1), .y_o(ia));
  lbr_ext #(.W(W)) u_ext_add (.x_i(add_i), .sz_i(sz_i), .sgn_i(1'b1), .y_o(aa));

  assign sum = ia + aa;
  assign low = sum[W-1:0];

  // wrapped value, sign-extended from operand width
  lbr_ext #(.W(W)) u_ext_res (.x_i(low), .sz_i(sz_i), .sgn_i(1'b1), .y_o(sres_o));

  assign ovf_o = (sres_o != sum);

  always_comb begin
    unique case (sz_i)
      SZ_B:    res_o = {idx_i[W-1:8], low[7:0]};
      SZ_H:    res_o = {idx_i[W-1:16], low[15:0]};
      default: res_o = low;
    endcase
  end
endmodule

// File: rtl/lbr_case_sel.sv
`timescale 1ns/1ps
module lbr_case_sel
  import lbr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] idx_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] lim_i,
  input  logic [1:0]   sz_i,
  output logic         hit_o,
  output logic [W:0]   sel_o
);
  logic [W-1:0] diff;
  logic [W:0]   dz, lz;

  assign diff = idx_i - base_i;

  lbr_ext #(.W(W)) u_ext_diff (.x_i(diff),  .sz_i(sz_i), .sgn_i(1'b0), .y_o(dz));
  lbr_ext #(.W(W)) u_ext_lim  (.x_i(lim_i), .sz_i(sz_i), .sgn_i(1'b0), .y_o(lz));

  // one unsigned compare rejects both sides of the table
  assign hit_o = (dz <= lz);
  assign sel_o = hit_o ? dz : lz + (W+1)'(1);
endmodule

// File: rtl/lbr_resolver.sv
`timescale 1ns/1ps
module lbr_resolver
  import lbr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [W-1:0]      index_i,
  input  logic [W-1:0]      limit_i,
  input  logic [W-1:0]      addend_i,
  input  logic [W-1:0]      base_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              valid_o,
  output logic [W-1:0]      index_o,
  output logic              taken_o,
  output logic [W:0]        sel_o,
  output logic [FLAG_W-1:0] flags_o
);
  op_e op;
  assign op = op_e'(op_i);

  logic is_acb, is_aob, is_sob, is_loop, is_case;
  assign is_acb  = (op == OP_ACB);
  assign is_aob  = (op == OP_AOB_LT) || (op == OP_AOB_LE);
  assign is_sob  = (op == OP_SOB_GT) || (op == OP_SOB_GE);
  assign is_loop = is_acb || is_aob || is_sob;
  assign is_case = (op == OP_CASE);

  logic [1:0] eff_sz;
  assign eff_sz = (is_acb || is_case) ? size_i : SZ_L;

  logic [W-1:0] step_add;
  always_comb begin
    if (is_acb)      step_add = addend_i;
    else if (is_aob) step_add = W'(1);
    else if (is_sob) step_add = '1;
    else             step_add = '0;
  end

  logic [W-1:0] step_res;
  logic [W:0]   step_sres;
  logic         step_ovf;

  lbr_step #(.W(W)) u_step (
    .idx_i (index_i),
    .add_i (step_add),
    .sz_i  (eff_sz),
    .res_o (step_res),
    .sres_o(step_sres),
    .ovf_o (step_ovf)
  );

  logic [W:0] lim_x, add_x;
  lbr_ext #(.W(W)) u_ext_lim (.x_i(limit_i),  .sz_i(eff_sz), .sgn_i(1'b1), .y_o(lim_x));
  lbr_ext #(.W(W)) u_ext_add (.x_i(addend_i), .sz_i(eff_sz), .sgn_i(1'b1), .y_o(add_x));

  logic       case_hit;
  logic [W:0] case_sel;
  lbr_case_sel #(.W(W)) u_case (
    .idx_i (index_i),
    .base_i(base_i),
    .lim_i (limit_i),
    .sz_i  (size_i),
    .hit_o (case_hit),
    .sel_o (case_sel)
  );

  logic signed [W:0] ns, ls;
  logic le, lt, ge, gtz, gez;
  assign ns  = $signed(step_sres);
  assign ls  = $signed(lim_x);
  assign le  = (ns <= ls);
  assign lt  = (ns < ls);
  assign ge  = (ns >= ls);
  assign gez = !step_sres[W];
  assign gtz = gez && (step_sres != '0);

  logic              taken_d;
  logic [W-1:0]      index_d;
  logic [W:0]        sel_d;
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    unique case (op)
      OP_ACB:     taken_d = add_x[W] ? ge : le;
      OP_AOB_LT:  taken_d = lt;
      OP_AOB_LE:  taken_d = le;
      OP_SOB_GT:  taken_d = gtz;
      OP_SOB_GE:  taken_d = gez;
      OP_BLB_CLR: taken_d = !index_i[0];
      OP_BLB_SET: taken_d = index_i[0];
      default:    taken_d = case_hit;
    endcase
  end

  assign index_d = is_loop ? step_res : index_i;
  assign sel_d   = is_case ? case_sel : '0;
  assign flags_d = is_loop ? {step_sres[W], (step_sres == '0), step_ovf, flags_i[0]}
                           : flags_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      index_o <= '0;
      taken_o <= 1'b0;
      sel_o   <= '0;
      flags_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        index_o <= index_d;
        taken_o <= taken_d;
        sel_o   <= sel_d;
        flags_o <= flags_d;
      end
    end
  end
endmodule

// File: rtl/lbr_resolver_chk.sv
`timescale 1ns/1ps
module lbr_resolver_chk
  import lbr_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [1:0]        size_i,
  input logic [W-1:0]      index_i,
  input logic [W-1:0]      limit_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              valid_o,
  input logic [W-1:0]      index_o,
  input logic              taken_o,
  input logic [W:0]        sel_o,
  input logic [FLAG_W-1:0] flags_o
);
  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(index_o) && $stable(taken_o) && $stable(sel_o) && $stable(flags_o)); // R1

  AST_CARRY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'd4) |=> flags_o[0] == $past(flags_i[0])); // R3

  AST_FLAGS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= 3'd5) |=> flags_o == $past(flags_i)); // R3

  AST_LOWBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_BLB_CLR || op_i == OP_BLB_SET)) |=>
      index_o == $past(index_i) && taken_o == ($past(index_i[0]) == ($past(op_i) == OP_BLB_SET))); // R6

  AST_DEC_GE_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SOB_GE) |=> taken_o == !index_o[W-1]); // R5

  AST_CASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CASE && size_i[1]) |=>
      (taken_o ? (sel_o <= {1'b0, $past(limit_i)}) : (sel_o == {1'b0, $past(limit_i)} + 1'b1))); // R8

  AST_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != OP_CASE) |=> sel_o == '0); // R8
endmodule

bind lbr_resolver lbr_resolver_chk #(.W(W)) u_chk (.*);

// File: tb/lbr_resolver_tb.sv
`timescale 1ns/1ps
module lbr_resolver_tb;
  localparam int W = 32;

  typedef struct {
    logic [31:0] idx;
    logic        tk;
    logic [32:0] sel;
    logic [3:0]  fl;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  sz = '0;
  logic [31:0] idx = '0, lim = '0, add = '0, base = '0;
  logic [3:0]  fl = '0;
  logic        valid_o, taken_o;
  logic [31:0] index_o;
  logic [32:0] sel_o;
  logic [3:0]  flags_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lbr_resolver #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .size_i(sz),
    .index_i(idx), .limit_i(lim), .addend_i(add), .base_i(base), .flags_i(fl),
    .valid_o(valid_o), .index_o(index_o), .taken_o(taken_o), .sel_o(sel_o),
    .flags_o(flags_o)
  );

  function automatic longint sx(longint v, int w);
    longint m = (longint'(1) << w) - 1;
    longint r = v & m;
    if (((r >> (w - 1)) & 1) != 0) r = r - (longint'(1) << w);
    return r;
  endfunction

  function automatic exp_t model(logic [2:0] o, logic [1:0] s, logic [31:0] i,
                                 logic [31:0] l, logic [31:0] a, logic [31:0] b,
                                 logic [3:0] f);
    exp_t e;
    int w = (o == 3'd0 || o == 3'd7) ? (s == 2'd0 ? 8 : (s == 2'd1 ? 16 : 32)) : 32;
    longint m = (longint'(1) << w) - 1;
    longint av, bv, sv, low, nv, lv, d, lz;
    e.idx = i; e.tk = 1'b0; e.sel = '0; e.fl = f;
    if (o <= 3'd4) begin
      av  = sx(longint'(i), w);
      bv  = (o == 3'd0) ? sx(longint'(a), w) : ((o <= 3'd2) ? 1 : -1);
      sv  = av + bv;
      low = sv & m;
      nv  = sx(low, w);
      lv  = sx(longint'(l), w);
      e.idx = 32'((longint'(i) & ~m) | low);
      e.fl  = {nv < 0, nv == 0, sv != nv, f[0]};
      case (o)
        3'd0: e.tk = (bv >= 0) ? (nv <= lv) : (nv >= lv);
        3'd1: e.tk = nv < lv;
        3'd2: e.tk = nv <= lv;
        3'd3: e.tk = nv > 0;
        default: e.tk = nv >= 0;
      endcase
    end else if (o != 3'd7) begin
      e.tk = (i[0] == (o == 3'd6));
    end else begin
      d  = (longint'(i) - longint'(b)) & m;
      lz = longint'(l) & m;
      e.tk  = d <= lz;
      e.sel = e.tk ? 33'(d) : 33'(lz + 1);
    end
    return e;
  endfunction

  function automatic string req_of(logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1, 3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      3'd5, 3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(string req, logic [2:0] o, logic [1:0] s, logic [31:0] i,
                       logic [31:0] l, logic [31:0] a, logic [31:0] b, logic [3:0] f);
    exp_t e;
    @(negedge clk);
    op = o; sz = s; idx = i; lim = l; add = a; base = b; fl = f; valid = 1'b1;
    e = model(o, s, i, l, a, b, f);
    @(negedge clk);
    valid = 1'b0;
    chk(req, "valid", longint'(valid_o), 1);
    chk(req, "index", longint'(index_o), longint'(e.idx));
    chk(req, "taken", longint'(taken_o), longint'(e.tk));
    chk(req, "sel",   longint'(sel_o),   longint'(e.sel));
    chk(req, "flags", longint'(flags_o), longint'(e.fl));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_idx;
    logic [32:0] hold_sel;
    logic [3:0]  hold_fl;
    logic        hold_tk;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset valid", longint'(valid_o), 0);
    chk("R1", "reset index", longint'(index_o), 0);
    chk("R1", "reset taken", longint'(taken_o), 0);
    chk("R1", "reset sel",   longint'(sel_o), 0);
    chk("R1", "reset flags", longint'(flags_o), 0);
    rst_n = 1'b1;

    // R2 step-compare at the limit, both directions
    apply("R2", 3'd0, 2'd2, 32'd5, 32'd8, 32'd3, 32'd0, 4'b0001);
    apply("R2", 3'd0, 2'd2, 32'd5, 32'd8, 32'd4, 32'd0, 4'b0000);
    apply("R2", 3'd0, 2'd2, 32'd10, 32'd8, 32'hFFFF_FFFE, 32'd0, 4'b0001);
    apply("R2", 3'd0, 2'd2, 32'd9, 32'd8, 32'hFFFF_FFFE, 32'd0, 4'b0000);
    // R9 R10 byte wrap keeps upper bits, sets V, branches on wrapped value
    apply("R10", 3'd0, 2'd0, 32'hAABB_CC7F, 32'h0000_007F, 32'd1, 32'd0, 4'b0001);
    // R9 R3 word wrap to zero
    apply("R9", 3'd0, 2'd1, 32'h1234_FFFF, 32'd0, 32'd1, 32'd0, 4'b1110);
    // R4 increment forms at the boundary
    apply("R4", 3'd1, 2'd0, 32'd9, 32'd10, 32'd0, 32'd0, 4'b0000);
    apply("R4", 3'd2, 2'd0, 32'd9, 32'd10, 32'd0, 32'd0, 4'b0000);
    apply("R10", 3'd1, 2'd0, 32'h7FFF_FFFF, 32'd0, 32'd0, 32'd0, 4'b0001);
    // R5 decrement forms around zero
    apply("R5", 3'd3, 2'd0, 32'd1, 32'd0, 32'd0, 32'd0, 4'b0000);
    apply("R5", 3'd4, 2'd0, 32'd1, 32'd0, 32'd0, 32'd0, 4'b0001);
    apply("R5", 3'd4, 2'd0, 32'd0, 32'd0, 32'd0, 32'd0, 4'b0000);
    // R6 low-bit tests with flags passing through
    apply("R6", 3'd5, 2'd0, 32'd2, 32'd0, 32'd0, 32'd0, 4'b1010);
    apply("R6", 3'd6, 2'd0, 32'd3, 32'd0, 32'd0, 32'd0, 4'b0101);
    apply("R6", 3'd6, 2'd0, 32'd2, 32'd0, 32'd0, 32'd0, 4'b1111);
    // R7 R8 case inside, past and below the table
    apply("R7", 3'd7, 2'd2, 32'd12, 32'd3, 32'd0, 32'd10, 4'b0011);
    apply("R8", 3'd7, 2'd2, 32'd14, 32'd3, 32'd0, 32'd10, 4'b0000);
    apply("R8", 3'd7, 2'd2, 32'd9, 32'd3, 32'd0, 32'd10, 4'b1000);
    apply("R8", 3'd7, 2'd2, 32'd0, 32'hFFFF_FFFE, 32'd0, 32'd1, 4'b0000);
    // R9 byte case ignores upper bits
    apply("R9", 3'd7, 2'd0, 32'h0000_0105, 32'h0000_0102, 32'd0, 32'd3, 4'b0000);
    apply("R9", 3'd7, 2'd1, 32'h0001_0000, 32'h0000_0005, 32'd0, 32'd1, 4'b0000);

    // R1 idle cycle holds the outputs
    hold_idx = index_o; hold_sel = sel_o; hold_fl = flags_o; hold_tk = taken_o;
    op = 3'd0; idx = 32'hDEAD_BEEF; add = 32'd7; fl = 4'b1111;
    @(negedge clk);
    chk("R1", "idle valid", longint'(valid_o), 0);
    chk("R1", "idle index", longint'(index_o), longint'(hold_idx));
    chk("R1", "idle sel",   longint'(sel_o),   longint'(hold_sel));
    chk("R1", "idle flags", longint'(flags_o), longint'(hold_fl));
    chk("R1", "idle taken", longint'(taken_o), longint'(hold_tk));

    // mixed patterns, small magnitudes to hit boundaries often
    for (int k = 0; k < 400; k++) begin
      logic [2:0]  ro;
      logic [31:0] ri, rl, ra, rb;
      ro = 3'($urandom);
      ri = (k % 2 == 0) ? 32'($urandom) : 32'($urandom_range(0, 20)) - 32'd10;
      rl = (k % 3 == 0) ? 32'($urandom) : 32'($urandom_range(0, 20)) - 32'd10;
      ra = 32'($urandom_range(0, 8)) - 32'd4;
      rb = 32'($urandom_range(0, 20)) - 32'd10;
      apply(req_of(ro), ro, 2'($urandom), ri, rl, ra, rb, 4'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule